// File: doc/BRIEF.md
# Radio Operating Mode Controller

This block is the mode sequencer of a packet radio transceiver. From a power-enable configuration bit, a receive-role bit, the chip-enable pin and the empty flag of the transmit queue, it decides which of eight operating modes the radio is in. The modes are: off, oscillator start-up, idle with the oscillator running, idle with the clocks kept up, transmit settling, transmit, receive settling and receive. From the mode it drives the enables of the oscillator, the synthesiser PLL, the power amplifier and the low-noise amplifier. It issues a one-cycle strobe that tells the baseband to start sending a packet, and the baseband answers with a one-cycle packet-done pulse.

Every interval is a count of clock cycles set by a parameter: oscillator start-up (with a separate count for an external clock source), PLL settling, the minimum chip-enable pulse that starts a transmission, and the longest time a single packet may keep the transmitter on. A per-packet watchdog enforces that last limit. When it expires, the transmitter is forced off and a sticky error flag is raised, and the flag stays set until the radio is powered down.

Top module: `radio_mode_ctrl`

## Requirements
- R1: While `power_on` is sampled low, the next mode is off (code 0) whatever the current mode. In the off mode all four enables are low and `tx_timeout` is low.
- R2: When `power_on` rises in the off mode, the controller spends exactly START cycles in oscillator start-up (code 1) and then enters idle-I (code 2). START is `XO_START_CYC`, or `EXT_START_CYC` when `USE_EXT_CLK` is set.
- R3: From idle-I, a cycle with `chip_en`=1 and `rx_role`=1 moves the controller into receive settling (code 6). In receive (code 7), `chip_en` sampled low returns it to idle-I on the next cycle.
- R4: From idle-I with `rx_role`=0, transmit settling (code 4) is entered only when `chip_en` has been sampled high on `CE_MIN_CYC` consecutive edges while `txq_empty`=0. A shorter pulse, or a pulse of any length while the queue is empty, leaves the mode at idle-I.
- R5: Each settling mode lasts exactly `SETTLE_CYC` cycles and is followed by its active mode. Every entry into transmit or receive, including a direct change from one to the other, passes through settling.
- R6: In transmit (code 5), the mode changes only on `pkt_done`, and then in this priority order: `chip_en`=0 goes to idle-I; `rx_role`=1 goes to receive settling; a non-empty queue stays in transmit for the next packet; otherwise the controller goes to idle-II (code 3).
- R7: `pkt_start` is high for exactly the first cycle of every packet in transmit. This covers entry from settling and each back-to-back packet after a `pkt_done`.
- R8: In idle-II, `chip_en`=0 goes to idle-I, and a non-empty queue while `chip_en`=1 and `rx_role`=0 goes to transmit settling.
- R9: If a packet gets no `pkt_done` within `TX_MAX_CYC` cycles of its `pkt_start`, the controller leaves transmit for idle-I after exactly `TX_MAX_CYC` cycles and sets `tx_timeout`. The flag stays set until the off mode is entered.
- R10: Enables follow the mode. `xo_en` is high in every mode except off. `pll_en` is high in both settling modes and both active modes. `pa_en` is high only in transmit and `lna_en` only in receive. `mode_oh` has bit k set exactly when `mode` equals k.
- R11: `pkt_done` outside the transmit mode has no effect on the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| power_on | input | 1 | Power-enable configuration bit |
| rx_role | input | 1 | 1 selects the receiver role, 0 the transmitter role |
| chip_en | input | 1 | Chip-enable pin (synchronous to clk) |
| txq_empty | input | 1 | Transmit queue holds no packet |
| pkt_done | input | 1 | One-cycle pulse from the baseband: current packet finished |
| mode | output | 3 | Current mode code (0 off … 7 receive) |
| mode_oh | output | 8 | One-hot copy of the mode |
| xo_en | output | 1 | Oscillator enable |
| pll_en | output | 1 | Synthesiser PLL enable |
| pa_en | output | 1 | Power amplifier enable |
| lna_en | output | 1 | Low-noise amplifier enable |
| pkt_start | output | 1 | One-cycle strobe: begin sending a packet |
| tx_timeout | output | 1 | Sticky flag: transmit watchdog expired |

## Verification
The bound checker watches the following on every cycle:
- the forced move to off and the cleared error flag in that mode;
- that transmit is reached only through settling or from transmit itself;
- that the start strobe appears only inside transmit and on every fresh entry to it;
- that no packet keeps the transmitter on longer than the watchdog limit;
- the amplifier enables against the mode.

The exact start-up and settling durations, the rejection of short or queue-less chip-enable pulses, and the priority of the decisions at packet end can only be shown by the directed scenarios. The same holds for the idle-II restart and the persistence of the timeout flag until power-down, because these depend on particular input sequences.

// File: rtl/rmc_pkg.sv
package rmc_pkg;

   typedef enum logic [2:0] {
      MD_OFF       = 3'd0,
      MD_XO_START  = 3'd1,
      MD_IDLE1     = 3'd2,
      MD_IDLE2     = 3'd3,
      MD_TX_SETTLE = 3'd4,
      MD_TX        = 3'd5,
      MD_RX_SETTLE = 3'd6,
      MD_RX        = 3'd7
   } rmc_mode_e;

   localparam int unsigned RMC_NUM_MODES = 8;

   function automatic int unsigned rmc_max(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/rmc_countdown.sv
module rmc_countdown #(
   parameter  int unsigned MAX_VAL = 16,
   localparam int unsigned W       = $clog2(MAX_VAL + 1)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         done
);

   logic [W-1:0] cnt_q;

   // A load of N makes done rise on the N-th cycle after the load edge.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val - 1'b1;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign done = (cnt_q == '0);

endmodule

// File: rtl/rmc_ce_qualifier.sv
module rmc_ce_qualifier #(
   parameter int unsigned MIN_HIGH_CYC = 160
) (
   input  logic clk,
   input  logic rst_n,
   input  logic chip_en,
   output logic held
);

   localparam int unsigned CW = $clog2(MIN_HIGH_CYC);
   localparam logic [CW-1:0] SAT = CW'(MIN_HIGH_CYC - 1);

   logic [CW-1:0] run_q;

   // Counts edges with chip_en high; any low sample restarts the count.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= '0;
      end else if (!chip_en) begin
         run_q <= '0;
      end else if (run_q != SAT) begin
         run_q <= run_q + 1'b1;
      end
   end

   // True on the MIN_HIGH_CYC-th consecutive high edge and afterwards.
   assign held = chip_en && (run_q == SAT);

endmodule

// File: rtl/rmc_mode_fsm.sv
module rmc_mode_fsm
   import rmc_pkg::*;
#(
   parameter int unsigned START_CYC  = 24000,
   parameter int unsigned SETTLE_CYC = 2080,
   parameter int unsigned TX_MAX_CYC = 64000,
   parameter int unsigned PW         = 16,
   parameter int unsigned WW         = 17
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          power_on,
   input  logic          rx_role,
   input  logic          chip_en,
   input  logic          ce_held,
   input  logic          txq_empty,
   input  logic          pkt_done,
   input  logic          phase_done,
   input  logic          wdog_done,
   output rmc_mode_e     state,
   output logic          phase_load,
   output logic [PW-1:0] phase_val,
   output logic          wdog_load,
   output logic [WW-1:0] wdog_val,
   output logic          pkt_start,
   output logic          tx_timeout
);

   localparam logic [PW-1:0] START_V  = PW'(START_CYC);
   localparam logic [PW-1:0] SETTLE_V = PW'(SETTLE_CYC);

   rmc_mode_e state_q, state_d;
   logic      launch;
   logic      expire;
   logic      pkt_start_q;
   logic      tmo_q;

   always_comb begin
      state_d    = state_q;
      phase_load = 1'b0;
      phase_val  = SETTLE_V;
      launch     = 1'b0;
      expire     = 1'b0;
      if (!power_on) begin
         state_d = MD_OFF;
      end else begin
         unique case (state_q)
            MD_OFF: begin
               state_d    = MD_XO_START;
               phase_load = 1'b1;
               phase_val  = START_V;
            end
            MD_XO_START: begin
               if (phase_done) state_d = MD_IDLE1;
            end
            MD_IDLE1: begin
               if (chip_en && rx_role) begin
                  state_d    = MD_RX_SETTLE;
                  phase_load = 1'b1;
               end else if (!rx_role && ce_held && !txq_empty) begin
                  state_d    = MD_TX_SETTLE;
                  phase_load = 1'b1;
               end
            end
            MD_IDLE2: begin
               if (!chip_en) begin
                  state_d = MD_IDLE1;
               end else if (rx_role) begin
                  state_d    = MD_RX_SETTLE;
                  phase_load = 1'b1;
               end else if (!txq_empty) begin
                  state_d    = MD_TX_SETTLE;
                  phase_load = 1'b1;
               end
            end
            MD_TX_SETTLE: begin
               if (phase_done) begin
                  state_d = MD_TX;
                  launch  = 1'b1;
               end
            end
            MD_TX: begin
               if (pkt_done) begin
                  if (!chip_en) begin
                     state_d = MD_IDLE1;
                  end else if (rx_role) begin
                     state_d    = MD_RX_SETTLE;
                     phase_load = 1'b1;
                  end else if (!txq_empty) begin
                     launch = 1'b1;
                  end else begin
                     state_d = MD_IDLE2;
                  end
               end else if (wdog_done) begin
                  state_d = MD_IDLE1;
                  expire  = 1'b1;
               end
            end
            MD_RX_SETTLE: begin
               if (phase_done) state_d = MD_RX;
            end
            MD_RX: begin
               if (!chip_en) begin
                  state_d = MD_IDLE1;
               end else if (!rx_role) begin
                  if (!txq_empty) begin
                     state_d    = MD_TX_SETTLE;
                     phase_load = 1'b1;
                  end else begin
                     state_d = MD_IDLE2;
                  end
               end
            end
            default: state_d = MD_OFF;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= MD_OFF;
         pkt_start_q <= 1'b0;
         tmo_q       <= 1'b0;
      end else begin
         state_q     <= state_d;
         pkt_start_q <= launch;
         if (!power_on) begin
            tmo_q <= 1'b0;
         end else if (expire) begin
            tmo_q <= 1'b1;
         end
      end
   end

   assign state      = state_q;
   assign wdog_load  = launch;
   assign wdog_val   = WW'(TX_MAX_CYC);
   assign pkt_start  = pkt_start_q;
   assign tx_timeout = tmo_q;

endmodule

// File: rtl/radio_mode_ctrl.sv
module radio_mode_ctrl
   import rmc_pkg::*;
#(
   parameter int unsigned XO_START_CYC  = 24000,
   parameter int unsigned EXT_START_CYC = 2400,
   parameter bit          USE_EXT_CLK   = 1'b0,
   parameter int unsigned SETTLE_CYC    = 2080,
   parameter int unsigned CE_MIN_CYC    = 160,
   parameter int unsigned TX_MAX_CYC    = 64000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       power_on,
   input  logic       rx_role,
   input  logic       chip_en,
   input  logic       txq_empty,
   input  logic       pkt_done,
   output logic [2:0] mode,
   output logic [7:0] mode_oh,
   output logic       xo_en,
   output logic       pll_en,
   output logic       pa_en,
   output logic       lna_en,
   output logic       pkt_start,
   output logic       tx_timeout
);

   localparam int unsigned START_CYC = USE_EXT_CLK ? EXT_START_CYC : XO_START_CYC;
   localparam int unsigned PHASE_MAX = rmc_max(START_CYC, SETTLE_CYC);
   localparam int unsigned PW        = $clog2(PHASE_MAX + 1);
   localparam int unsigned WW        = $clog2(TX_MAX_CYC + 1);

   // Elaboration-time parameter checks
   if (XO_START_CYC < 1 || EXT_START_CYC < 1) begin : g_bad_start
      $error("radio_mode_ctrl: start-up counts must be at least 1");
   end
   if (SETTLE_CYC < 1) begin : g_bad_settle
      $error("radio_mode_ctrl: SETTLE_CYC must be at least 1");
   end
   if (CE_MIN_CYC < 2) begin : g_bad_ce
      $error("radio_mode_ctrl: CE_MIN_CYC must be at least 2");
   end
   if (TX_MAX_CYC < 2) begin : g_bad_wdog
      $error("radio_mode_ctrl: TX_MAX_CYC must be at least 2");
   end

   rmc_mode_e       state;
   logic            ce_held;
   logic            phase_load, phase_done;
   logic [PW-1:0]   phase_val;
   logic            wdog_load, wdog_done;
   logic [WW-1:0]   wdog_val;

   rmc_ce_qualifier #(
      .MIN_HIGH_CYC (CE_MIN_CYC)
   ) u_ce_qual (
      .clk     (clk),
      .rst_n   (rst_n),
      .chip_en (chip_en),
      .held    (ce_held)
   );

   rmc_countdown #(
      .MAX_VAL (PHASE_MAX)
   ) u_phase_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (phase_load),
      .load_val (phase_val),
      .done     (phase_done)
   );

   rmc_countdown #(
      .MAX_VAL (TX_MAX_CYC)
   ) u_wdog_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (wdog_load),
      .load_val (wdog_val),
      .done     (wdog_done)
   );

   rmc_mode_fsm #(
      .START_CYC  (START_CYC),
      .SETTLE_CYC (SETTLE_CYC),
      .TX_MAX_CYC (TX_MAX_CYC),
      .PW         (PW),
      .WW         (WW)
   ) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .power_on   (power_on),
      .rx_role    (rx_role),
      .chip_en    (chip_en),
      .ce_held    (ce_held),
      .txq_empty  (txq_empty),
      .pkt_done   (pkt_done),
      .phase_done (phase_done),
      .wdog_done  (wdog_done),
      .state      (state),
      .phase_load (phase_load),
      .phase_val  (phase_val),
      .wdog_load  (wdog_load),
      .wdog_val   (wdog_val),
      .pkt_start  (pkt_start),
      .tx_timeout (tx_timeout)
   );

   assign mode = state;

   for (genvar k = 0; k < RMC_NUM_MODES; k++) begin : g_onehot
      assign mode_oh[k] = (state == rmc_mode_e'(k));
   end

   assign xo_en  = (state != MD_OFF);
   assign pll_en = (state == MD_TX_SETTLE) || (state == MD_TX) ||
                   (state == MD_RX_SETTLE) || (state == MD_RX);
   assign pa_en  = (state == MD_TX);
   assign lna_en = (state == MD_RX);

endmodule

// File: rtl/rmc_checker.sv
module rmc_checker #(
   parameter int unsigned TX_MAX_CYC = 64000
) (
   input logic       clk,
   input logic       rst_n,
   input logic       power_on,
   input logic       pkt_done,
   input logic [2:0] mode,
   input logic       pa_en,
   input logic       lna_en,
   input logic       pkt_start,
   input logic       tx_timeout
);

   localparam logic [2:0] C_OFF = 3'd0, C_IDLE1 = 3'd2, C_TXS = 3'd4, C_TX = 3'd5, C_RX = 3'd7;
   localparam int unsigned RW = $clog2(TX_MAX_CYC + 1);

   logic [RW-1:0] tx_run_q;

   // Cycles spent in transmit since the current packet's start strobe.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_run_q <= '0;
      end else if (mode != C_TX) begin
         tx_run_q <= '0;
      end else if (pkt_start) begin
         tx_run_q <= RW'(1);
      end else if (tx_run_q != RW'(TX_MAX_CYC)) begin
         tx_run_q <= tx_run_q + 1'b1;
      end
   end

   // R1
   off_on_power_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !power_on |=> mode == C_OFF);

   // R1
   off_clears_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mode == C_OFF |-> !tx_timeout);

   // R5
   tx_via_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mode == C_TX |-> ($past(mode) == C_TX || $past(mode) == C_TXS));

   // R7
   start_inside_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_start |-> mode == C_TX);

   // R7
   start_on_tx_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == C_TX && $past(mode) != C_TX) |-> pkt_start);

   // R7
   start_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == C_TX && $past(mode) == C_TX && !$past(pkt_done)) |-> !pkt_start);

   // R9
   tx_time_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == C_TX && !pkt_start) |-> tx_run_q < RW'(TX_MAX_CYC));

   // R9
   timeout_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_timeout) |-> mode == C_IDLE1);

   // R10
   amp_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pa_en |-> mode == C_TX) and (lna_en |-> mode == C_RX));

endmodule

bind radio_mode_ctrl rmc_checker #(
   .TX_MAX_CYC (TX_MAX_CYC)
) u_rmc_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .power_on   (power_on),
   .pkt_done   (pkt_done),
   .mode       (mode),
   .pa_en      (pa_en),
   .lna_en     (lna_en),
   .pkt_start  (pkt_start),
   .tx_timeout (tx_timeout)
);

// File: tb/radio_mode_ctrl_bench.sv
`timescale 1ns/1ps
module radio_mode_ctrl_bench;

   localparam int XO_C   = 40;
   localparam int EXT_C  = 8;
   localparam int SET_C  = 12;
   localparam int CEM_C  = 5;
   localparam int TXM_C  = 60;

   localparam int M_OFF = 0, M_XO = 1, M_ID1 = 2, M_ID2 = 3;
   localparam int M_TXS = 4, M_TX = 5, M_RXS = 6, M_RX = 7;

   logic clk = 1'b0;
   logic rst_n, power_on, rx_role, chip_en, txq_empty, pkt_done;
   logic [2:0] mode;
   logic [7:0] mode_oh;
   logic xo_en, pll_en, pa_en, lna_en, pkt_start, tx_timeout;

   int n_checks = 0;
   int n_err    = 0;

   always #2 clk = ~clk;

   radio_mode_ctrl #(
      .XO_START_CYC  (XO_C),
      .EXT_START_CYC (EXT_C),
      .USE_EXT_CLK   (1'b0),
      .SETTLE_CYC    (SET_C),
      .CE_MIN_CYC    (CEM_C),
      .TX_MAX_CYC    (TXM_C)
   ) u_radio_mode_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .power_on   (power_on),
      .rx_role    (rx_role),
      .chip_en    (chip_en),
      .txq_empty  (txq_empty),
      .pkt_done   (pkt_done),
      .mode       (mode),
      .mode_oh    (mode_oh),
      .xo_en      (xo_en),
      .pll_en     (pll_en),
      .pa_en      (pa_en),
      .lna_en     (lna_en),
      .pkt_start  (pkt_start),
      .tx_timeout (tx_timeout)
   );

   task automatic check(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic dwell(input int m, output int n);
      n = 0;
      while (int'(mode) == m && n < 5000) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic done_pulse();
      pkt_done = 1'b1;
      tick(1);
      pkt_done = 1'b0;
   endtask

   task automatic t_reset();
      rst_n = 1'b0; power_on = 1'b0; rx_role = 1'b0;
      chip_en = 1'b0; txq_empty = 1'b1; pkt_done = 1'b0;
      tick(3);
      rst_n = 1'b1;
      tick(2);
      check("R1 mode after reset", int'(mode), M_OFF);
      check("R1 enables after reset", int'({xo_en, pll_en, pa_en, lna_en}), 0);
      check("R1 flags after reset", int'({pkt_start, tx_timeout}), 0);
      check("R10 one-hot in off", int'(mode_oh), 1);
   endtask

   task automatic t_power_up();
      int n;
      power_on = 1'b1;
      tick(1);
      check("R2 start-up mode", int'(mode), M_XO);
      check("R10 xo_en in start-up", int'({xo_en, pll_en}), 2);
      dwell(M_XO, n);
      check("R2 start-up length", n, XO_C);
      check("R2 idle-I after start-up", int'(mode), M_ID1);
      check("R10 idle-I enables", int'({xo_en, pll_en, pa_en, lna_en}), 8);
   endtask

   task automatic t_ce_reject();
      rx_role = 1'b0; txq_empty = 1'b0;
      chip_en = 1'b1;
      tick(CEM_C - 1);
      chip_en = 1'b0;
      tick(3);
      check("R4 short pulse ignored", int'(mode), M_ID1);
      txq_empty = 1'b1;
      chip_en = 1'b1;
      tick(CEM_C + 2);
      check("R4 empty queue blocks transmit", int'(mode), M_ID1);
      chip_en = 1'b0; txq_empty = 1'b0;
      tick(1);
   endtask

   task automatic t_tx_pulse();
      int n;
      chip_en = 1'b1;
      tick(CEM_C);
      check("R4 qualified pulse starts settling", int'(mode), M_TXS);
      chip_en = 1'b0;
      dwell(M_TXS, n);
      check("R5 transmit settling length", n, SET_C);
      check("R7 transmit entered with strobe", int'({mode == 3'(M_TX), pkt_start}), 3);
      check("R10 transmit enables", int'({xo_en, pll_en, pa_en, lna_en}), 14);
      tick(1);
      check("R7 strobe lasts one cycle", int'(pkt_start), 0);
      tick(2);
      done_pulse();
      check("R6 done with chip_en low gives idle-I", int'(mode), M_ID1);
   endtask

   task automatic t_stream();
      chip_en = 1'b1; txq_empty = 1'b0;
      tick(CEM_C + SET_C);
      check("R7 stream first packet", int'({mode == 3'(M_TX), pkt_start}), 3);
      tick(2);
      done_pulse();
      check("R6 non-empty queue keeps transmit", int'(mode), M_TX);
      check("R7 back-to-back strobe", int'(pkt_start), 1);
      txq_empty = 1'b1;
      tick(2);
      done_pulse();
      check("R6 empty queue gives idle-II", int'(mode), M_ID2);
      check("R10 idle-II enables", int'({xo_en, pll_en, pa_en, lna_en}), 8);
      tick(3);
      check("R8 idle-II holds while queue empty", int'(mode), M_ID2);
      txq_empty = 1'b0;
      tick(1);
      check("R8 new packet restarts settling", int'(mode), M_TXS);
      tick(SET_C);
      check("R8 transmit after restart", int'(mode), M_TX);
   endtask

   task automatic t_tx_to_rx();
      int n;
      rx_role = 1'b1;
      tick(2);
      check("R6 role change waits for packet end", int'(mode), M_TX);
      done_pulse();
      check("R5 direct change passes through settling", int'(mode), M_RXS);
      dwell(M_RXS, n);
      check("R5 receive settling length", n, SET_C);
      check("R3 receive mode", int'(mode), M_RX);
      check("R10 receive enables", int'({xo_en, pll_en, pa_en, lna_en}), 13);
      done_pulse();
      check("R11 done pulse ignored in receive", int'(mode), M_RX);
      chip_en = 1'b0;
      tick(1);
      check("R3 chip_en low leaves receive", int'(mode), M_ID1);
      done_pulse();
      check("R11 done pulse ignored in idle-I", int'(mode), M_ID1);
   endtask

   task automatic t_watchdog();
      int n;
      rx_role = 1'b0; txq_empty = 1'b0; chip_en = 1'b1;
      tick(CEM_C + SET_C);
      check("R9 transmit before watchdog", int'(mode), M_TX);
      dwell(M_TX, n);
      chip_en = 1'b0;
      check("R9 watchdog limit", n, TXM_C);
      check("R9 watchdog exit mode", int'(mode), M_ID1);
      check("R9 timeout flag set", int'(tx_timeout), 1);
      tick(3);
      check("R9 timeout flag sticky", int'(tx_timeout), 1);
   endtask

   task automatic t_power_down();
      rx_role = 1'b1; chip_en = 1'b1;
      tick(1);
      check("R3 idle-I to receive settling", int'(mode), M_RXS);
      tick(SET_C);
      check("R3 receive before power-down", int'(mode), M_RX);
      power_on = 1'b0;
      tick(1);
      check("R1 power-down from receive", int'(mode), M_OFF);
      check("R1 enables off", int'({xo_en, pll_en, pa_en, lna_en}), 0);
      check("R1 timeout flag cleared", int'(tx_timeout), 0);
   endtask

   initial begin
      t_reset();
      t_power_up();
      t_ce_reject();
      t_tx_pulse();
      t_stream();
      t_tx_to_rx();
      t_watchdog();
      t_power_down();
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_checks++;
      n_err++;
      $display("FAIL watchdog (all requirements): actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
   end

endmodule